// File: doc/BRIEF.md
# Prescaled Auto-Reload Interval Timer

This block is a memory-mapped up-counting timer. A clock divider, set by a 16-bit prescale register, gives one count tick every (prescale + 1) clock cycles. On each tick the counter moves up by one. When the counter has reached the reload limit, the tick wraps it to zero and produces an update event. If the update interrupt is enabled, that event latches a status flag and drives a one-cycle pulse on the interrupt line. Four compare registers are provided. They only hold values and have no effect on the timer.

Software reaches every register through a simple write strobe and a read strobe on a 0x400-byte window. Software can load the counter directly. It can force the counter and the divider back to zero through a software event bit. It can change the prescale value without disturbing the count. A reload limit of zero turns update events off completely.

Top module: `tick_reload_timer`

## Requirements
- R1: After reset every register reads zero, including the counter, the status flag and the prescale value, and `irq` is low.
- R2: Each register sits at a fixed byte offset: control 0x00, interrupt enable 0x0C, status 0x10, event 0x14, counter 0x24, prescale 0x28, reload limit 0x2C, and compare 0..3 at 0x34, 0x38, 0x3C, 0x40. Control, interrupt enable, event, reload limit and compare read back the last value written. Read data appears on `rdata` in the cycle after `rd_en` is sampled, and `rdata` is zero in every cycle that follows a cycle without `rd_en`.
- R3: The prescale register keeps only bits 15:0 of a write. Its upper bits read as zero.
- R4: Reads from an offset that is not in the map return zero, and writes to such an offset change nothing. Address bits 1:0 are ignored.
- R5: While control bit 0 (enable) is 1, the counter advances once every (prescale + 1) clock cycles. While it is 0, the counter and the divider hold their values.
- R6: If the counter equals a non-zero reload limit A on a tick, it becomes 0 on that tick and an update event fires. With prescale P, updates therefore repeat every (A + 1)(P + 1) cycles after enable, the first one coming (A + 1)(P + 1) cycles after the enabling write.
- R7: An update event sets status bit 0 and pulses `irq` high for exactly one cycle, but only when interrupt-enable bit 0 and the enable bit are both 1. With interrupt-enable bit 0 at 0, nothing is flagged.
- R8: A write to the status register ANDs bit 0 of the written data into the flag. Writing 0 clears the flag, writing 1 leaves it as it is, and a flag being set in the same cycle wins.
- R9: A write to the counter register loads the written value as the new count. The write takes priority over a tick in the same cycle, and counting continues from the loaded value.
- R10: Writing the event register with bit 0 set zeroes both the counter and the divider, and produces no update event.
- R11: Writing a new prescale value leaves the current count unchanged.
- R12: While the reload limit is zero, no update event is produced and the counter runs freely, wrapping at its full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (10) | Byte address inside the register window |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, registered, zero when no read was made |
| irq | output | 1 | One-cycle update interrupt pulse |

## Verification
The assertions check, on every cycle, several properties that relate the pieces of logic to each other:
- an interrupt pulse lasts one cycle, arrives only with the flag set, and comes only after both enable bits were set and the reload limit was non-zero;
- an update always leaves the counter at zero;
- the software event always clears the counter and the divider;
- the counter holds whenever there is no tick and no software access;
- read data is zero after any cycle without a read.

Only the bench's scenarios can show the exact update period across a sweep of prescale and reload values, the free-running count while the reload limit is zero, and the address decoding of mapped and unmapped offsets. The same holds for the flag's AND-write semantics, for loading the counter followed by wrapping, and for the count surviving a prescale change.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Byte offsets of the mapped registers
  localparam int OFS_CTRL  = 'h000;
  localparam int OFS_IEN   = 'h00C;
  localparam int OFS_STAT  = 'h010;
  localparam int OFS_EVT   = 'h014;
  localparam int OFS_CNT   = 'h024;
  localparam int OFS_PSC   = 'h028;
  localparam int OFS_RLD   = 'h02C;
  localparam int OFS_CMP0  = 'h034;

  // Bit positions inside control, interrupt-enable, status and event
  localparam int BIT_RUN   = 0;
  localparam int BIT_UIE   = 0;
  localparam int BIT_UFLAG = 0;
  localparam int BIT_SWUPD = 0;

  // Divider finished its span: a count tick is due
  function automatic logic fn_div_done(input logic run,
                                       input logic [31:0] div,
                                       input logic [31:0] lim);
    return run && (div >= lim);
  endfunction

  // Counter at a non-zero reload limit: the next tick wraps it
  function automatic logic fn_at_limit(input logic [63:0] cnt,
                                       input logic [63:0] lim);
    return (lim != 64'd0) && (cnt == lim);
  endfunction

  // Status flag after an AND-style software write and a hardware set
  function automatic logic fn_flag_next(input logic cur,
                                        input logic wr,
                                        input logic keep,
                                        input logic set);
    return set | (cur & (keep | ~wr));
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] limit,
  output logic [PSC_W-1:0] div_q,
  output logic             tick
);
  import tmr_pkg::*;

  assign tick = !restart && fn_div_done(run, 32'(div_q), 32'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (restart || tick) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= div_q + PSC_W'(1);
    end
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clear,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] limit,
  output logic [DATA_W-1:0] cnt_q,
  output logic              upd
);
  import tmr_pkg::*;

  logic at_limit;
  assign at_limit = fn_at_limit(64'(cnt_q), 64'(limit));
  assign upd      = tick && !clear && !load && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (upd) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + DATA_W'(1);
    end
  end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 10,
  parameter int PSC_W   = 16,
  parameter int NUM_CMP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] cnt_val,
  input  logic              flag_set,
  output logic              cen,
  output logic              uie,
  output logic              sr_flag,
  output logic [PSC_W-1:0]  psc,
  output logic [DATA_W-1:0] arr,
  output logic              ug_wr,
  output logic              cnt_wr
);
  import tmr_pkg::*;

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  assign widx = addr[ADDR_W-1:2];

  logic unused_addr_bits;
  assign unused_addr_bits = ^addr[1:0];

  logic sel_ctrl, sel_ien, sel_stat, sel_evt, sel_cnt, sel_psc, sel_rld;
  logic [NUM_CMP-1:0] sel_cmp;

  assign sel_ctrl = (widx == WIDX_W'(OFS_CTRL >> 2));
  assign sel_ien  = (widx == WIDX_W'(OFS_IEN  >> 2));
  assign sel_stat = (widx == WIDX_W'(OFS_STAT >> 2));
  assign sel_evt  = (widx == WIDX_W'(OFS_EVT  >> 2));
  assign sel_cnt  = (widx == WIDX_W'(OFS_CNT  >> 2));
  assign sel_psc  = (widx == WIDX_W'(OFS_PSC  >> 2));
  assign sel_rld  = (widx == WIDX_W'(OFS_RLD  >> 2));

  logic [DATA_W-1:0] ctrl_q, ien_q, evt_q, rld_q;
  logic [PSC_W-1:0]  psc_q;
  logic              flag_q;
  logic [DATA_W-1:0] cmp_q [NUM_CMP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      evt_q  <= '0;
      rld_q  <= '0;
      psc_q  <= '0;
    end else if (wr_en) begin
      if (sel_ctrl) ctrl_q <= wdata;
      if (sel_ien)  ien_q  <= wdata;
      if (sel_evt)  evt_q  <= wdata;
      if (sel_rld)  rld_q  <= wdata;
      if (sel_psc)  psc_q  <= wdata[PSC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= fn_flag_next(flag_q, wr_en && sel_stat, wdata[BIT_UFLAG], flag_set);
    end
  end

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    assign sel_cmp[k] = (widx == WIDX_W'((OFS_CMP0 >> 2) + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q[k] <= '0;
      end else if (wr_en && sel_cmp[k]) begin
        cmp_q[k] <= wdata;
      end
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) rd_mux = ctrl_q;
    if (sel_ien)  rd_mux = ien_q;
    if (sel_stat) rd_mux = DATA_W'(flag_q);
    if (sel_evt)  rd_mux = evt_q;
    if (sel_cnt)  rd_mux = cnt_val;
    if (sel_psc)  rd_mux = DATA_W'(psc_q);
    if (sel_rld)  rd_mux = rld_q;
    for (int k = 0; k < NUM_CMP; k++) begin
      if (sel_cmp[k]) rd_mux = cmp_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else begin
      rdata <= rd_en ? rd_mux : '0;
    end
  end

  assign cen     = ctrl_q[BIT_RUN];
  assign uie     = ien_q[BIT_UIE];
  assign sr_flag = flag_q;
  assign psc     = psc_q;
  assign arr     = rld_q;
  assign ug_wr   = wr_en && sel_evt && wdata[BIT_SWUPD];
  assign cnt_wr  = wr_en && sel_cnt;

endmodule

// File: rtl/tick_reload_timer.sv
module tick_reload_timer #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 10,
  parameter int PSC_W   = 16,
  parameter int NUM_CMP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  logic              cen, uie, sr_flag, ug_wr, cnt_wr, tick, upd, flag_set;
  logic [PSC_W-1:0]  psc, pdiv;
  logic [DATA_W-1:0] arr, cnt;

  assign flag_set = upd && uie;

  tmr_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PSC_W(PSC_W), .NUM_CMP(NUM_CMP)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cnt_val(cnt), .flag_set(flag_set),
    .cen(cen), .uie(uie), .sr_flag(sr_flag), .psc(psc), .arr(arr),
    .ug_wr(ug_wr), .cnt_wr(cnt_wr)
  );

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(cen), .restart(ug_wr), .limit(psc),
    .div_q(pdiv), .tick(tick)
  );

  tmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(ug_wr), .load(cnt_wr),
    .load_val(wdata), .limit(arr), .cnt_q(cnt), .upd(upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= flag_set;
  end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int DATA_W = 32,
  parameter int PSC_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic              cen,
  input logic              uie,
  input logic              sr_flag,
  input logic              tick,
  input logic              upd,
  input logic [DATA_W-1:0] cnt,
  input logic [PSC_W-1:0]  pdiv,
  input logic              ug_wr,
  input logic              cnt_wr,
  input logic [DATA_W-1:0] arr
);

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sr_flag);

  assert_irq_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(uie) && $past(cen)));

  assert_no_update_at_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(arr) != '0));

  assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (cnt == '0));

  assert_sw_event_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ug_wr |=> ((cnt == '0) && (pdiv == '0)));

  assert_hold_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ug_wr && !cnt_wr) |=> $stable(cnt));

  assert_no_tick_when_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cen |-> !tick);

  assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));

endmodule

bind tick_reload_timer tmr_checker #(.DATA_W(DATA_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rdata(rdata), .irq(irq),
  .cen(cen), .uie(uie), .sr_flag(sr_flag), .tick(tick), .upd(upd),
  .cnt(cnt), .pdiv(pdiv), .ug_wr(ug_wr), .cnt_wr(cnt_wr), .arr(arr)
);

// File: tb/tb_tick_reload_timer.sv
`timescale 1ns/1ps
module tb_tick_reload_timer;

  localparam logic [9:0] A_CTRL = 10'h000;
  localparam logic [9:0] A_IEN  = 10'h00C;
  localparam logic [9:0] A_STAT = 10'h010;
  localparam logic [9:0] A_EVT  = 10'h014;
  localparam logic [9:0] A_CNT  = 10'h024;
  localparam logic [9:0] A_PSC  = 10'h028;
  localparam logic [9:0] A_RLD  = 10'h02C;
  localparam logic [9:0] A_CMP0 = 10'h034;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tick_reload_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int p_list [4];
    int a_list [4];
    p_list = '{0, 1, 2, 3};
    a_list = '{1, 2, 3, 5};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of all registers and the interrupt
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rdata idle", rdata, 0);
    for (int k = 0; k < 15; k++) begin
      if (k != 1 && k != 2 && k != 6 && k != 7 && k != 8 && k != 12) begin
        rd(10'(k * 4), v);
        chk($sformatf("R1 reg at %0h", k * 4), v, 0);
      end
    end

    // R2: readback of plain storage registers
    wr(A_IEN, 32'h0000_0000);
    wr(A_RLD, 32'hDEAD_0007);
    wr(A_EVT, 32'h0000_0002);
    for (int k = 0; k < 4; k++) wr(A_CMP0 + 10'(k * 4), 32'h1111_0000 + 32'(k * 3));
    rd(A_RLD, v); chk("R2 reload limit", v, 32'hDEAD_0007);
    rd(A_EVT, v); chk("R2 event reg", v, 32'h2);
    for (int k = 0; k < 4; k++) begin
      rd(A_CMP0 + 10'(k * 4), v);
      chk($sformatf("R2 compare %0d", k), v, 32'h1111_0000 + 32'(k * 3));
    end
    rd(A_CNT, v); chk("R2 counter untouched by event bit1", v, 0);

    // R3: prescale keeps low 16 bits
    wr(A_PSC, 32'hABCD_1234);
    rd(A_PSC, v); chk("R3 prescale width", v, 32'h0000_1234);

    // R4: unmapped offsets and ignored low address bits
    wr(10'h004, 32'hFFFF_FFFF);
    wr(10'h030, 32'hFFFF_FFFF);
    wr(10'h3FC, 32'hFFFF_FFFF);
    rd(10'h004, v); chk("R4 unmapped 0x004", v, 0);
    rd(10'h030, v); chk("R4 unmapped 0x030", v, 0);
    rd(10'h3FC, v); chk("R4 unmapped 0x3FC", v, 0);
    rd(A_RLD + 10'd2, v); chk("R4 low bits ignored", v, 32'hDEAD_0007);
    rd(A_CTRL, v); chk("R4 control unchanged", v, 0);
    rd(A_CNT, v); chk("R4 counter unchanged", v, 0);

    // R6/R7: update period sweep with interrupt enabled
    foreach (p_list[pi]) begin
      foreach (a_list[ai]) begin
        int t, first, second, highs;
        t = (a_list[ai] + 1) * (p_list[pi] + 1);
        wr(A_CTRL, 0);
        wr(A_IEN, 1);
        wr(A_PSC, 32'(p_list[pi]));
        wr(A_RLD, 32'(a_list[ai]));
        wr(A_STAT, 0);
        wr(A_EVT, 1);
        wr(A_CTRL, 1);
        first = 0; second = 0; highs = 0;
        for (int n = 1; n <= 2 * t + 1; n++) begin
          @(negedge clk);
          if (irq) begin
            highs++;
            if (first == 0) first = n;
            else if (second == 0) second = n;
          end
        end
        chk($sformatf("R6 first update P=%0d A=%0d", p_list[pi], a_list[ai]), 32'(first), 32'(t));
        chk($sformatf("R6 second update P=%0d A=%0d", p_list[pi], a_list[ai]), 32'(second), 32'(2 * t));
        chk($sformatf("R7 pulse cycles P=%0d A=%0d", p_list[pi], a_list[ai]), 32'(highs), 2);
        wr(A_CTRL, 0);
        rd(A_STAT, v);
        chk($sformatf("R7 flag P=%0d A=%0d", p_list[pi], a_list[ai]), v, 1);
      end
    end

    // R8: AND semantics of the status write (flag currently 1)
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R8 write one keeps flag", v, 1);
    wr(A_STAT, 32'hFFFF_FFFE);
    rd(A_STAT, v); chk("R8 write zero clears flag", v, 0);

    // R7: interrupt disabled gives no flag and no pulse
    begin
      int highs;
      wr(A_IEN, 0);
      wr(A_PSC, 0);
      wr(A_RLD, 2);
      wr(A_EVT, 1);
      wr(A_CTRL, 1);
      highs = 0;
      for (int n = 0; n < 20; n++) begin
        @(negedge clk);
        if (irq) highs++;
      end
      wr(A_CTRL, 0);
      chk("R7 no pulse when disabled", 32'(highs), 0);
      rd(A_STAT, v); chk("R7 no flag when disabled", v, 0);
    end

    // R5/R12: free count with reload limit zero, no updates
    foreach (p_list[pi]) begin
      for (int w = 7; w <= 13; w += 6) begin
        int highs;
        wr(A_CTRL, 0);
        wr(A_IEN, 1);
        wr(A_RLD, 0);
        wr(A_PSC, 32'(p_list[pi]));
        wr(A_EVT, 1);
        wr(A_CTRL, 1);
        highs = 0;
        for (int n = 0; n < w; n++) begin
          @(negedge clk);
          if (irq) highs++;
        end
        rd(A_CNT, v);
        chk($sformatf("R5 count P=%0d W=%0d", p_list[pi], w), v, 32'(w / (p_list[pi] + 1)));
        chk($sformatf("R12 no pulse P=%0d W=%0d", p_list[pi], w), 32'(highs), 0);
      end
    end
    wr(A_CTRL, 0);
    rd(A_STAT, v); chk("R12 no flag with zero limit", v, 0);

    // R5: hold while disabled
    begin
      logic [31:0] v0;
      rd(A_CNT, v0);
      repeat (10) @(negedge clk);
      rd(A_CNT, v);
      chk("R5 hold while disabled", v, v0);
    end

    // R9: load then continue to wrap
    wr(A_CNT, 32'h0000_0007);
    rd(A_CNT, v); chk("R9 load value", v, 7);
    wr(A_PSC, 0);
    wr(A_RLD, 4);
    wr(A_IEN, 1);
    wr(A_EVT, 1);
    wr(A_CNT, 3);
    wr(A_CTRL, 1);
    @(negedge clk); chk("R9 no update one tick after load", 32'(irq), 0);
    @(negedge clk); chk("R9 update after loaded count reaches limit", 32'(irq), 1);
    wr(A_CTRL, 0);
    wr(A_STAT, 0);

    // R11: prescale change keeps count
    wr(A_CNT, 5);
    wr(A_PSC, 3);
    rd(A_CNT, v); chk("R11 count kept on prescale write", v, 5);

    // R10: software event zeroes counter without update
    wr(A_RLD, 5);
    wr(A_CNT, 5);
    wr(A_EVT, 1);
    rd(A_CNT, v); chk("R10 counter zeroed", v, 0);
    rd(A_STAT, v); chk("R10 no flag from software event", v, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule